// File: doc/BRIEF.md
# Power Controller Mode Sequencer

This block is the digital mode sequencer of a switching power-factor controller. It takes already-digitized comparator flags from the analog front end and steps the controller through six operating modes: sleep, standby, soft-start, normal run, an overvoltage fault and a peak-current fault. From the present mode and the flags it drives the gate enable, the oscillator enable, the internal bias enable and the compensation-node discharge. It also reports a mode code.

All flag inputs are asynchronous to the clock and pass through multi-flop synchronizers. The gate enable is the exception to the registered mode path. It is decoded combinationally from the synchronized overvoltage, peak-current and compensation-low flags. As a result, a protection event removes the gate in the same cycle that the synchronized flag appears, one cycle before the mode register moves to the fault state.

Two details follow the way the analog loop behaves. Brown-out detection uses one of two line thresholds, selected by whether the controller has started since the last sleep. A sleep request from the enable pin passes through standby until the compensation node has been discharged, so the next start always begins from a discharged node and soft-starts.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode code is 0 (sleep): gate, oscillator and bias enables are low and compensation discharge is high. Mode codes are 0 sleep, 1 standby, 2 soft-start, 3 normal, 4 overvoltage fault, 5 peak-current fault.
- R2: Supply below lockout moves every mode to sleep, ahead of all other conditions.
- R3: Sleep is left for standby only while the supply is above turn-on, not below lockout, and the enable pin is not below its sleep level.
- R4: Standby moves to soft-start only when three conditions hold together: feedback is not in open loop, line-sense is above its enable level, and the compensation node is below its start level. A pre-biased node holds standby.
- R5: Before the first soft-start since sleep, brown-out means line-sense not above its enable level. After that, brown-out means line-sense below the lower brown-out level. Brown-out moves any biased mode to standby.
- R6: Feedback below the open-loop level moves any biased mode to standby.
- R7: Soft-start moves to normal when the soft-start-complete flag is seen.
- R8: An overvoltage trip in soft-start or normal drops the gate in the cycle the synchronized flag appears, then enters the overvoltage fault. The fault is held until both pins are below the reset level, and then the mode returns to the one it left.
- R9: A peak-current flag in soft-start or normal drops the gate in the cycle the synchronized flag appears, then enters the peak-current fault. The fault clears back to the previous mode as soon as the flag drops.
- R10: Compensation discharge is high in sleep and standby. An enable-pin sleep request from a biased mode goes to standby first and reaches sleep only once the compensation node is below its start level.
- R11: Bias is off only in sleep. The oscillator runs in soft-start, normal and both fault modes. The gate is enabled only in soft-start or normal while the compensation node is above its start level.
- R12: When conditions coincide, the order is sleep, then standby, then overvoltage, then peak current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_lo_i | input | 1 | Supply below lockout level |
| en_sleep_i | input | 1 | Enable pin below sleep level |
| line_en_i | input | 1 | Line-sense above enable level |
| line_bo_i | input | 1 | Line-sense below brown-out level |
| fb_olp_i | input | 1 | Feedback below open-loop level |
| ovp_trip_i | input | 1 | Feedback or overvoltage pin above trip level |
| ovp_clr_i | input | 1 | Both overvoltage inputs below reset level |
| ipk_i | input | 1 | Current-sense magnitude above peak limit |
| comp_low_i | input | 1 | Compensation node below start level |
| ss_done_i | input | 1 | Soft-start complete |
| gate_en_o | output | 1 | Gate drive enable |
| osc_en_o | output | 1 | Oscillator enable |
| bias_en_o | output | 1 | Internal bias enable |
| comp_dis_o | output | 1 | Compensation node discharge |
| state_o | output | 3 | Mode code |

## Verification
The bench builds the block with the default two-stage synchronizer, so a flag change reaches the gate after two edges and the mode register after three. With this skew the bench can observe the gate already low while the mode code still reads normal, which separates the combinational protection path from the registered transition. The bench derives every sampling point from its own synchronizer-depth constant. With that constant it can place coincident flags on the same edge to exercise the priority order, and it can hold the compensation node high to show that both start-up and enable-pin sleep wait for it.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_STBY  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_NORM  = 3'd3,
    ST_OVPF  = 3'd4,
    ST_IPKF  = 3'd5
  } pms_state_e;

  localparam int FLAG_W   = 11;
  localparam int F_VCC_ON = 0;
  localparam int F_VCC_LO = 1;
  localparam int F_SLEEP  = 2;
  localparam int F_LN_EN  = 3;
  localparam int F_LN_BO  = 4;
  localparam int F_OLP    = 5;
  localparam int F_OVP    = 6;
  localparam int F_OVPCLR = 7;
  localparam int F_IPK    = 8;
  localparam int F_CMPLO  = 9;
  localparam int F_SSDONE = 10;
endpackage

// File: rtl/pms_rst_sync.sv
module pms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on,
  input  logic       vcc_lo,
  input  logic       en_sleep,
  input  logic       line_en,
  input  logic       line_bo,
  input  logic       fb_olp,
  input  logic       ovp_trip,
  input  logic       ovp_clr,
  input  logic       ipk,
  input  logic       comp_low,
  input  logic       ss_done,
  output logic       gate_en_o,
  output logic       osc_en_o,
  output logic       bias_en_o,
  output logic       comp_dis_o,
  output logic [2:0] state_o
);
  pms_state_e state_q, state_d, resume_q, resume_d;
  logic       started_q, started_d, started_en, resume_en;
  logic       brown, stby_req, sleep_req, running;

  // Next-state logic; the order of tests is the priority order
  always_comb begin
    brown     = started_q ? line_bo : !line_en;
    sleep_req = vcc_lo || (en_sleep && comp_low);
    stby_req  = fb_olp || brown || en_sleep;
    state_d   = state_q;
    if (state_q == ST_SLEEP) begin
      if (vcc_on && !vcc_lo && !en_sleep) state_d = ST_STBY;
    end else if (sleep_req) begin
      state_d = ST_SLEEP;
    end else if (stby_req) begin
      state_d = ST_STBY;
    end else begin
      unique case (state_q)
        ST_STBY: if (comp_low && line_en) state_d = ST_SOFT;
        ST_SOFT: begin
          if      (ovp_trip) state_d = ST_OVPF;
          else if (ipk)      state_d = ST_IPKF;
          else if (ss_done)  state_d = ST_NORM;
        end
        ST_NORM: begin
          if      (ovp_trip) state_d = ST_OVPF;
          else if (ipk)      state_d = ST_IPKF;
        end
        ST_OVPF: if (ovp_clr) state_d = resume_q;
        ST_IPKF: begin
          if      (ovp_trip) state_d = ST_OVPF;
          else if (!ipk)     state_d = resume_q;
        end
        default: state_d = ST_SLEEP;
      endcase
    end
  end

  // Side registers and their clock enables
  always_comb begin
    started_en = (state_d == ST_SLEEP) || (state_d == ST_SOFT);
    started_d  = (state_d == ST_SOFT);
    resume_en  = (state_q == ST_SOFT) || (state_q == ST_NORM);
    resume_d   = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SLEEP;
      started_q <= 1'b0;
      resume_q  <= ST_SOFT;
    end else begin
      state_q <= state_d;
      if (started_en) started_q <= started_d;
      if (resume_en)  resume_q  <= resume_d;
    end
  end

  // Output decode; gate path is combinational from the synchronized flags
  assign running    = (state_q == ST_SOFT) || (state_q == ST_NORM);
  assign gate_en_o  = running && !ovp_trip && !ipk && !comp_low;
  assign osc_en_o   = running || (state_q == ST_OVPF) || (state_q == ST_IPKF);
  assign bias_en_o  = (state_q != ST_SLEEP);
  assign comp_dis_o = (state_q == ST_SLEEP) || (state_q == ST_STBY);
  assign state_o    = state_q;

  AST_LOCKOUT_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_lo |=> state_q == ST_SLEEP); // R2
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && !(vcc_on && !vcc_lo && !en_sleep)) |=> state_q == ST_SLEEP); // R3
  AST_START_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && !(comp_low && line_en && !fb_olp)) |=> state_q != ST_SOFT); // R4
  AST_BROWNOUT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && line_bo && !vcc_lo && !en_sleep) |=> state_q == ST_STBY); // R5
  AST_OPEN_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SLEEP && fb_olp && !vcc_lo && !(en_sleep && comp_low)) |=> state_q == ST_STBY); // R6
  AST_OVP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVPF && !ovp_clr) |=> state_q inside {ST_OVPF, ST_STBY, ST_SLEEP}); // R8
  AST_IPK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IPKF && ipk) |=> state_q inside {ST_IPKF, ST_OVPF, ST_STBY, ST_SLEEP}); // R9
  AST_SLEEP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SLEEP && !vcc_lo && !comp_low) |=> state_q != ST_SLEEP); // R10
  AST_GATE_BIASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_o |-> (bias_en_o && osc_en_o && !comp_dis_o)); // R11
  AST_OVP_OVER_IPK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && ovp_trip && ipk && !vcc_lo && !stby_req) |=> state_q == ST_OVPF); // R12
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_on_i,
  input  logic       vcc_lo_i,
  input  logic       en_sleep_i,
  input  logic       line_en_i,
  input  logic       line_bo_i,
  input  logic       fb_olp_i,
  input  logic       ovp_trip_i,
  input  logic       ovp_clr_i,
  input  logic       ipk_i,
  input  logic       comp_low_i,
  input  logic       ss_done_i,
  output logic       gate_en_o,
  output logic       osc_en_o,
  output logic       bias_en_o,
  output logic       comp_dis_o,
  output logic [2:0] state_o
);
  logic              rst_sync_n;
  logic [FLAG_W-1:0] raw, syn;

  always_comb begin
    raw           = '0;
    raw[F_VCC_ON] = vcc_on_i;
    raw[F_VCC_LO] = vcc_lo_i;
    raw[F_SLEEP]  = en_sleep_i;
    raw[F_LN_EN]  = line_en_i;
    raw[F_LN_BO]  = line_bo_i;
    raw[F_OLP]    = fb_olp_i;
    raw[F_OVP]    = ovp_trip_i;
    raw[F_OVPCLR] = ovp_clr_i;
    raw[F_IPK]    = ipk_i;
    raw[F_CMPLO]  = comp_low_i;
    raw[F_SSDONE] = ss_done_i;
  end

  pms_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  pms_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (raw),
    .q_o   (syn)
  );

  pms_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .vcc_on    (syn[F_VCC_ON]),
    .vcc_lo    (syn[F_VCC_LO]),
    .en_sleep  (syn[F_SLEEP]),
    .line_en   (syn[F_LN_EN]),
    .line_bo   (syn[F_LN_BO]),
    .fb_olp    (syn[F_OLP]),
    .ovp_trip  (syn[F_OVP]),
    .ovp_clr   (syn[F_OVPCLR]),
    .ipk       (syn[F_IPK]),
    .comp_low  (syn[F_CMPLO]),
    .ss_done   (syn[F_SSDONE]),
    .gate_en_o (gate_en_o),
    .osc_en_o  (osc_en_o),
    .bias_en_o (bias_en_o),
    .comp_dis_o(comp_dis_o),
    .state_o   (state_o)
  );
endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_on, vcc_lo, en_sleep, line_en, line_bo, fb_olp;
  logic ovp_trip, ovp_clr, ipk, comp_low, ss_done;
  logic gate_en, osc_en, bias_en, comp_dis;
  logic [2:0] state;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.SYNC_STAGES(SYNC)) u_pwr_mode_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .vcc_on_i(vcc_on), .vcc_lo_i(vcc_lo), .en_sleep_i(en_sleep),
    .line_en_i(line_en), .line_bo_i(line_bo), .fb_olp_i(fb_olp),
    .ovp_trip_i(ovp_trip), .ovp_clr_i(ovp_clr), .ipk_i(ipk),
    .comp_low_i(comp_low), .ss_done_i(ss_done),
    .gate_en_o(gate_en), .osc_en_o(osc_en), .bias_en_o(bias_en),
    .comp_dis_o(comp_dis), .state_o(state)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic do_reset();
    vcc_on = 0; vcc_lo = 1; en_sleep = 0; line_en = 0; line_bo = 0;
    fb_olp = 0; ovp_trip = 0; ovp_clr = 1; ipk = 0; comp_low = 1; ss_done = 0;
    rst_n = 0;
    wait_edges(3);
    rst_n = 1;
    wait_edges(4);
  endtask

  task automatic go_normal();
    vcc_lo = 0; vcc_on = 1; line_en = 1; comp_low = 1;
    wait_edges(LAT + 3);
    chk("R4 reach soft-start", state, 2);
    comp_low = 0; ss_done = 1;
    wait_edges(LAT + 1);
    chk("R7 reach normal", state, 3);
  endtask

  task automatic t_startup();
    do_reset();
    chk("R1 reset state", state, 0);
    chk("R1 reset gate", gate_en, 0);
    chk("R1 reset osc", osc_en, 0);
    chk("R1 reset bias", bias_en, 0);
    chk("R1 reset discharge", comp_dis, 1);
    vcc_lo = 0; vcc_on = 1; line_en = 1; comp_low = 0;
    wait_edges(LAT + 3);
    chk("R4 pre-bias holds standby", state, 1);
    chk("R10 discharge in standby", comp_dis, 1);
    comp_low = 1;
    wait_edges(LAT);
    chk("R4 start on discharged node", state, 2);
    chk("R11 gate off while comp low", gate_en, 0);
    chk("R11 osc on in soft-start", osc_en, 1);
    comp_low = 0;
    wait_edges(SYNC);
    chk("R11 gate on above start level", gate_en, 1);
    chk("R7 no done flag stays soft", state, 2);
    ss_done = 1;
    wait_edges(LAT);
    chk("R7 done moves to normal", state, 3);
  endtask

  task automatic t_brownout();
    do_reset();
    vcc_lo = 0; vcc_on = 1; line_en = 0; comp_low = 1;
    wait_edges(LAT + 4);
    chk("R5 pre-start needs enable level", state, 1);
    do_reset();
    go_normal();
    line_en = 0;
    wait_edges(LAT + 2);
    chk("R5 enable level ignored after start", state, 3);
    line_bo = 1;
    wait_edges(LAT);
    chk("R5 brown-out to standby", state, 1);
    chk("R10 discharge after brown-out", comp_dis, 1);
    chk("R11 gate off in standby", gate_en, 0);
    line_bo = 0; comp_low = 1;
    wait_edges(LAT + 2);
    chk("R4 restart needs enable level", state, 1);
    line_en = 1;
    wait_edges(LAT);
    chk("R4 restart to soft-start", state, 2);
  endtask

  task automatic t_ovp();
    do_reset();
    go_normal();
    ovp_trip = 1; ovp_clr = 0;
    wait_edges(SYNC);
    chk("R8 gate drops with flag", gate_en, 0);
    chk("R8 mode not yet moved", state, 3);
    wait_edges(1);
    chk("R8 enter ovp fault", state, 4);
    chk("R8 osc runs in fault", osc_en, 1);
    ovp_trip = 0;
    wait_edges(LAT + 2);
    chk("R8 hold until reset level", state, 4);
    chk("R8 gate held off", gate_en, 0);
    ovp_clr = 1;
    wait_edges(LAT);
    chk("R8 resume normal", state, 3);
  endtask

  task automatic t_ipk();
    do_reset();
    go_normal();
    ipk = 1;
    wait_edges(SYNC);
    chk("R9 gate drops with flag", gate_en, 0);
    chk("R9 mode not yet moved", state, 3);
    wait_edges(1);
    chk("R9 enter peak fault", state, 5);
    chk("R9 osc runs in fault", osc_en, 1);
    ipk = 0;
    wait_edges(LAT);
    chk("R9 clear to normal", state, 3);
    chk("R9 gate back on", gate_en, 1);
  endtask

  task automatic t_priority();
    do_reset();
    go_normal();
    ovp_trip = 1; ovp_clr = 0; ipk = 1;
    wait_edges(LAT);
    chk("R12 ovp over peak", state, 4);
    ovp_trip = 0; ovp_clr = 1; ipk = 0;
    wait_edges(LAT + 2);
    chk("R12 back to normal", state, 3);
    fb_olp = 1; ovp_trip = 1; ovp_clr = 0;
    wait_edges(LAT);
    chk("R6 R12 open loop over ovp", state, 1);
    vcc_lo = 1;
    wait_edges(LAT);
    chk("R2 R12 lockout to sleep", state, 0);
    chk("R11 bias off in sleep", bias_en, 0);
  endtask

  task automatic t_sleep_en();
    do_reset();
    go_normal();
    en_sleep = 1;
    wait_edges(LAT);
    chk("R10 enable sleep goes standby first", state, 1);
    chk("R10 discharge asserted", comp_dis, 1);
    wait_edges(3);
    chk("R10 waits for node", state, 1);
    comp_low = 1;
    wait_edges(LAT);
    chk("R10 sleep after discharge", state, 0);
    chk("R11 bias off in sleep", bias_en, 0);
    wait_edges(LAT + 2);
    chk("R3 enable low holds sleep", state, 0);
    vcc_on = 0; en_sleep = 0;
    wait_edges(LAT + 2);
    chk("R3 no turn-on holds sleep", state, 0);
    vcc_on = 1;
    wait_edges(LAT);
    chk("R3 exit to standby", state, 1);
  endtask

  initial begin
    t_startup();
    t_brownout();
    t_ovp();
    t_ipk();
    t_priority();
    t_sleep_en();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule